// File: doc/BRIEF.md
# Busy-Interrupt Serial ADC Readback Controller

This block is the host-side sequencer for a 16-bit successive-approximation converter that runs in chip-select mode with an end-of-conversion indicator. When the host logic pulses `start_i`, the block drives the converter's data-in line high and then raises the convert line, which starts a conversion. It drops the data-in line well before the shortest possible conversion ends. It then watches the converter's data-out line, which a pull-up keeps high. When that line falls, the conversion is done and the converter is ready to be read. The block synchronises the line, clocks out the result with its own serial clock, shifts the bits in most significant first, and presents the word with a one-cycle valid strobe. It lowers the convert line one cycle later.

The convert line stays separate from the readout, so the sampling instant depends only on when a request arrives. The block does not wait out a fixed worst-case conversion time. The converter's own falling data line acts as the interrupt. If that edge never arrives within the longest conversion time plus a margin, the block releases the convert line and pulses a timeout flag instead of a data strobe. After every conversion, whether it succeeded or timed out, the block enforces an acquisition interval before it accepts another request.

All timings are counted in system clocks and set by parameters: the lead time of data-in before convert, the data-in high time after convert, the conversion bounds, the timeout margin, the acquisition time and the serial-clock half period. Whether bits are captured on the rising or the falling serial-clock edge is also a parameter.

Top module: `adc_busy_reader`

## Requirements
- R1: `ready_o` is high only while the block is idle. A `start_i` pulse is accepted only while `ready_o` is high, and a pulse at any other time starts no conversion, now or later.
- R2: After an accepted start, `sdi_o` is high for exactly T_LEAD cycles with `cnv_o` low, and `sdi_o` is still high in the cycle where `cnv_o` rises.
- R3: `sdi_o` stays high for exactly T_SDI_HI cycles after `cnv_o` rises, which is fewer than T_CONV_MIN. It then stays low until `cnv_o` falls.
- R4: Readback starts only after a high-to-low transition of `sdo_i` while the block waits for the conversion, so `sck_o` never pulses before that edge.
- R5: A readback issues exactly DATA_W+1 = 17 `sck_o` pulses. Each high phase lasts SCK_HALF cycles, and `sck_o` idles low. The pulse after the last data bit returns the converter's output to high impedance.
- R6: The converter presents bit D(16-k) after `sck_o` falling edge k, for k = 1..16. The captured word appears on `data_o` with D15 in bit 15, and it holds until the next capture.
- R7: `valid_o` is a single-cycle pulse issued while `cnv_o` is still high, and `cnv_o` falls in the cycle after it.
- R8: If `sdo_i` does not fall within T_CONV_MAX+T_MARGIN cycles after `sdi_o` falls, `cnv_o` drops after being high for exactly T_SDI_HI+T_CONV_MAX+T_MARGIN cycles. In the first cycle it is low, `timeout_o` pulses once. No `sck_o` pulse and no `valid_o` occur.
- R9: After `cnv_o` falls, `ready_o` stays low for exactly T_ACQ cycles with `sdi_o` and `cnv_o` low.
- R10: While `rst_n` is low and right after it is released, `cnv_o`, `sdi_o`, `sck_o`, `valid_o` and `timeout_o` are low, `data_o` is zero and `ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion request pulse |
| sdo_i | input | 1 | Converter serial data out, pulled up when released |
| cnv_o | output | 1 | Convert line to the converter |
| sdi_o | output | 1 | Converter data-in line, used as mode select |
| sck_o | output | 1 | Serial clock to the converter |
| data_o | output | DATA_W | Last captured conversion word |
| valid_o | output | 1 | One-cycle strobe for a new word |
| timeout_o | output | 1 | One-cycle strobe for a missing end-of-conversion edge |
| ready_o | output | 1 | High while idle and able to take a request |

## Verification
A sequencer stuck in or skipping a phase shows at once as a wrong count of cycles with `sdi_o` high before or after the rise of `cnv_o`. It can also show as a missing acquisition gap. A fault in the edge detector or the serial clock generator shows up in the same transaction as serial-clock pulses before the end-of-conversion edge, a pulse count other than 17, or high phases of the wrong length. A shift or capture fault appears as a wrong `data_o` at the `valid_o` strobe that ends that readback. A faulty timeout path shows as a wrong high time on `cnv_o` or a missing `timeout_o` pulse within one conversion window.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SDIHI,
    ST_WAIT,
    ST_READ,
    ST_PRESENT,
    ST_ACQ
  } rd_state_e;

  function automatic int unsigned wait_window(int unsigned conv_max, int unsigned margin);
    return conv_max + margin;
  endfunction

  function automatic int unsigned cnt_width(int unsigned value);
    return (value < 2) ? 1 : $clog2(value + 1);
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_rd_sdo_sync.sv
module adc_rd_sdo_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sdo_i,
  output logic sdo_s_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q[0] <= 1'b1;
    else        chain_q[0] <= sdo_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain_q[g] <= 1'b1;
      else        chain_q[g] <= chain_q[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign sdo_s_o = chain_q[STAGES-1];
  assign fall_o  = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/adc_rd_sck_shift.sv
module adc_rd_sck_shift
  import adc_rd_pkg::*;
#(
  parameter int unsigned DATA_W         = 16,
  parameter int unsigned SCK_HALF       = 4,
  parameter bit          SAMPLE_ON_FALL = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              sdo_i,
  output logic              sck_o,
  output logic [DATA_W-1:0] word_o,
  output logic              done_o,
  output logic              sample_o
);
  localparam int unsigned PULSES = DATA_W + 1;
  localparam int unsigned HW     = cnt_width(SCK_HALF);
  localparam int unsigned PW     = cnt_width(PULSES);

  logic [HW-1:0]     half_q;
  logic [PW-1:0]     pulse_q;
  logic              sck_q;
  logic              done_q;
  logic [DATA_W-1:0] sh_q;

  logic half_wrap, edge_rise, edge_fall, data_edge, sample_w, last_fall;

  assign half_wrap = run_i && !done_q && (half_q == HW'(SCK_HALF - 1));
  assign edge_rise = half_wrap && !sck_q;
  assign edge_fall = half_wrap && sck_q;

  if (SAMPLE_ON_FALL) begin : g_fall_capture
    assign data_edge = edge_fall;
  end else begin : g_rise_capture
    assign data_edge = edge_rise;
  end

  // the first falling edge only moves the busy level off the line
  assign sample_w  = data_edge && (pulse_q != '0);
  assign last_fall = edge_fall && (pulse_q == PW'(PULSES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_q  <= '0;
      pulse_q <= '0;
      sck_q   <= 1'b0;
      done_q  <= 1'b0;
      sh_q    <= '0;
    end else if (!run_i) begin
      half_q  <= '0;
      pulse_q <= '0;
      sck_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (half_wrap)     half_q <= '0;
      else if (!done_q)  half_q <= half_q + 1'b1;
      if (half_wrap)     sck_q <= ~sck_q;
      if (edge_fall)     pulse_q <= pulse_q + 1'b1;
      if (sample_w)      sh_q <= {sh_q[DATA_W-2:0], sdo_i};
      if (last_fall)     done_q <= 1'b1;
    end
  end

  assign sck_o    = sck_q;
  assign word_o   = sh_q;
  assign done_o   = done_q;
  assign sample_o = sample_w;
endmodule

// File: rtl/adc_busy_reader.sv
module adc_busy_reader
  import adc_rd_pkg::*;
#(
  parameter int unsigned DATA_W         = 16,
  parameter int unsigned SCK_HALF       = 4,
  parameter int unsigned T_LEAD         = 2,
  parameter int unsigned T_SDI_HI       = 4,
  parameter int unsigned T_CONV_MIN     = 20,
  parameter int unsigned T_CONV_MAX     = 40,
  parameter int unsigned T_MARGIN       = 8,
  parameter int unsigned T_ACQ          = 10,
  parameter int unsigned SYNC_STAGES    = 2,
  parameter bit          SAMPLE_ON_FALL = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              sdo_i,
  output logic              cnv_o,
  output logic              sdi_o,
  output logic              sck_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              timeout_o,
  output logic              ready_o
);
  localparam int unsigned WAIT_CYC = wait_window(T_CONV_MAX, T_MARGIN);
  localparam int unsigned TMAX     = max2(max2(T_LEAD, T_SDI_HI), max2(WAIT_CYC, T_ACQ));
  localparam int unsigned TW       = cnt_width(TMAX);

  rd_state_e         st_q, st_d;
  logic              tm_load;
  logic [TW-1:0]     tm_val;
  logic              tm_expired;
  logic              sdo_s, sdo_fall_w;
  logic              rd_run_w, rd_done_w, rd_sample_w;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] data_q;
  logic              tout_q, tout_d;

  adc_rd_sdo_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .sdo_i   (sdo_i),
    .sdo_s_o (sdo_s),
    .fall_o  (sdo_fall_w)
  );

  adc_rd_timer #(.W(TW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (tm_load),
    .val_i     (tm_val),
    .expired_o (tm_expired)
  );

  assign rd_run_w = (st_q == ST_READ);

  adc_rd_sck_shift #(
    .DATA_W         (DATA_W),
    .SCK_HALF       (SCK_HALF),
    .SAMPLE_ON_FALL (SAMPLE_ON_FALL)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (rd_run_w),
    .sdo_i    (sdo_s),
    .sck_o    (sck_o),
    .word_o   (rd_word),
    .done_o   (rd_done_w),
    .sample_o (rd_sample_w)
  );

  always_comb begin
    st_d    = st_q;
    tm_load = 1'b0;
    tm_val  = '0;
    tout_d  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_d = ST_LEAD; tm_load = 1'b1; tm_val = TW'(T_LEAD - 1);
      end
      ST_LEAD: if (tm_expired) begin
        st_d = ST_SDIHI; tm_load = 1'b1; tm_val = TW'(T_SDI_HI - 1);
      end
      ST_SDIHI: if (tm_expired) begin
        st_d = ST_WAIT; tm_load = 1'b1; tm_val = TW'(WAIT_CYC - 1);
      end
      ST_WAIT: begin
        if (sdo_fall_w) begin
          st_d = ST_READ;
        end else if (tm_expired) begin
          st_d = ST_ACQ; tm_load = 1'b1; tm_val = TW'(T_ACQ - 1); tout_d = 1'b1;
        end
      end
      ST_READ: if (rd_done_w) st_d = ST_PRESENT;
      ST_PRESENT: begin
        st_d = ST_ACQ; tm_load = 1'b1; tm_val = TW'(T_ACQ - 1);
      end
      ST_ACQ: if (tm_expired) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      data_q <= '0;
      tout_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      tout_q <= tout_d;
      if (rd_run_w && rd_done_w) data_q <= rd_word;
    end
  end

  assign cnv_o     = (st_q == ST_SDIHI) || (st_q == ST_WAIT) ||
                     (st_q == ST_READ)  || (st_q == ST_PRESENT);
  assign sdi_o     = (st_q == ST_LEAD) || (st_q == ST_SDIHI);
  assign ready_o   = (st_q == ST_IDLE);
  assign valid_o   = (st_q == ST_PRESENT);
  assign timeout_o = tout_q;
  assign data_o    = data_q;
endmodule

// File: rtl/adc_busy_reader_chk.sv
module adc_busy_reader_chk #(
  parameter int unsigned T_CONV_MIN = 20,
  parameter int unsigned PULSES     = 17
) (
  input logic clk,
  input logic rst_n,
  input logic cnv_o,
  input logic sdi_o,
  input logic sck_o,
  input logic valid_o,
  input logic timeout_o,
  input logic ready_o
);
  logic [15:0] sdi_hi_cnt;
  logic [15:0] rise_cnt;
  logic        sck_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sdi_hi_cnt <= '0;
      rise_cnt   <= '0;
      sck_prev   <= 1'b0;
    end else begin
      sck_prev <= sck_o;
      if (!cnv_o)      sdi_hi_cnt <= '0;
      else if (sdi_o)  sdi_hi_cnt <= sdi_hi_cnt + 1'b1;
      if (!cnv_o)                   rise_cnt <= '0;
      else if (sck_o && !sck_prev)  rise_cnt <= rise_cnt + 1'b1;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (!cnv_o && !sdi_o && !sck_o));
  assert_sdi_at_cnv_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv_o) |-> sdi_o);
  assert_sdi_before_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv_o && sdi_o) |-> (sdi_hi_cnt < 16'(T_CONV_MIN)));
  assert_sdi_stays_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv_o && !sdi_o) |=> !sdi_o);
  assert_sck_inside_cnv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sck_o |-> cnv_o);
  assert_sck_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_o |-> (rise_cnt <= 16'(PULSES)));
  assert_valid_under_cnv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> cnv_o);
  assert_valid_then_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> (!valid_o && !cnv_o));
  assert_timeout_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> (!cnv_o && !valid_o && !ready_o));
  assert_acq_after_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnv_o) |-> !ready_o);
endmodule

bind adc_busy_reader adc_busy_reader_chk #(
  .T_CONV_MIN (T_CONV_MIN),
  .PULSES     (DATA_W + 1)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnv_o     (cnv_o),
  .sdi_o     (sdi_o),
  .sck_o     (sck_o),
  .valid_o   (valid_o),
  .timeout_o (timeout_o),
  .ready_o   (ready_o)
);

// File: tb/adc_busy_reader_test.sv
module adc_busy_reader_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW         = 16;
  localparam int HALF       = 4;
  localparam int LEAD       = 2;
  localparam int SDIHI      = 4;
  localparam int CMIN       = 20;
  localparam int CMAX       = 40;
  localparam int MARGIN     = 8;
  localparam int ACQ        = 10;
  localparam int RESP_DLY   = 30;
  localparam int WD_CYCLES  = 100000;
  localparam int NVEC       = 7;
  // {converter answers, word}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b1, 16'hA5C3}, {1'b1, 16'h0000}, {1'b1, 16'hFFFF}, {1'b0, 16'h0000},
    {1'b1, 16'h8001}, {1'b1, 16'h1234}, {1'b1, 16'h7FFE}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic sdo_i = 1'b1;
  logic cnv_o, sdi_o, sck_o, valid_o, timeout_o, ready_o;
  logic [DW-1:0] data_o;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_busy_reader #(
    .DATA_W(DW), .SCK_HALF(HALF), .T_LEAD(LEAD), .T_SDI_HI(SDIHI),
    .T_CONV_MIN(CMIN), .T_CONV_MAX(CMAX), .T_MARGIN(MARGIN), .T_ACQ(ACQ),
    .SYNC_STAGES(2), .SAMPLE_ON_FALL(1'b0)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sdo_i(sdo_i),
    .cnv_o(cnv_o), .sdi_o(sdi_o), .sck_o(sck_o), .data_o(data_o),
    .valid_o(valid_o), .timeout_o(timeout_o), .ready_o(ready_o)
  );

  // converter model, acting at the falling clock edge
  logic [15:0] m_word = '0;
  bit  m_respond = 1'b1;
  bit  m_conv = 0, m_busy = 0, m_prev_cnv = 0, m_prev_sck = 0;
  int  m_tmr = 0, m_bit = 0;

  always @(negedge clk) begin
    if (cnv_o && !m_prev_cnv) begin
      m_conv = 1; m_tmr = 0; m_busy = 0; sdo_i = 1'b1;
    end
    if (m_conv) begin
      m_tmr++;
      if (m_respond && m_tmr == RESP_DLY) begin
        sdo_i = 1'b0; m_busy = 1; m_bit = 0; m_conv = 0;
      end
    end
    if (!sck_o && m_prev_sck && m_busy) begin
      if (m_bit < 16) begin sdo_i = m_word[15 - m_bit]; m_bit++; end
      else begin sdo_i = 1'b1; m_busy = 0; end
    end
    if (!cnv_o) begin sdo_i = 1'b1; m_conv = 0; m_busy = 0; end
    m_prev_cnv = cnv_o;
    m_prev_sck = sck_o;
  end

  // port monitor
  int lead_c, sdihi_c, cnvhi_c, rises_c, acq_c, sckr_c, early_c, badhalf_c;
  int vcnt_c, vbad_c, tcnt_c, tbad_c, hirun;
  bit fell_seen, vcnv, p_cnv, p_sck, p_valid, got_fall;
  logic [15:0] vdata;

  task automatic mon_clear();
    lead_c = 0; sdihi_c = 0; cnvhi_c = 0; rises_c = 0; acq_c = 0; sckr_c = 0;
    early_c = 0; badhalf_c = 0; vcnt_c = 0; vbad_c = 0; tcnt_c = 0; tbad_c = 0;
    fell_seen = 0; vcnv = 0; vdata = '0; got_fall = 0;
  endtask

  always @(negedge clk) begin
    if (!cnv_o && sdi_o) lead_c++;
    if (cnv_o && sdi_o) sdihi_c++;
    if (cnv_o) cnvhi_c++;
    if (cnv_o && !p_cnv) rises_c++;
    if (!cnv_o && p_cnv) fell_seen = 1;
    if (fell_seen && !cnv_o && !ready_o && !sdi_o) acq_c++;
    if (!sdo_i && cnv_o) got_fall = 1;
    if (sck_o && !p_sck) begin sckr_c++; if (!got_fall) early_c++; end
    if (sck_o) hirun++;
    if (!sck_o && p_sck) begin if (hirun != HALF) badhalf_c++; hirun = 0; end
    if (valid_o) begin vcnt_c++; vdata = data_o; vcnv = cnv_o; end
    if (p_valid && (valid_o || cnv_o)) vbad_c++;
    if (timeout_o) begin tcnt_c++; if (cnv_o) tbad_c++; end
    p_cnv = cnv_o; p_sck = sck_o; p_valid = valid_o;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start_i = 1'b1;
    @(posedge clk); #1 start_i = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1;
      if (fell_seen && ready_o) break;
    end
  endtask

  task automatic run_conv(input logic [15:0] w, input bit resp, input bit poke);
    m_word = w; m_respond = resp;
    @(posedge clk); #1 mon_clear();
    pulse_start();
    if (poke) begin
      repeat (10) @(posedge clk);
      #1 start_i = 1'b1; @(posedge clk); #1 start_i = 1'b0;
    end
    wait_done();
    chk("R2 lead cycles", lead_c, LEAD);
    chk("R3 sdi high after cnv", sdihi_c, SDIHI);
    chk("R3 below min conversion", int'(sdihi_c < CMIN), 1);
    chk("R9 acquisition cycles", acq_c, ACQ);
    chk("R1 conversions started", rises_c, 1);
    if (resp) begin
      chk("R4 sck before end of conversion", early_c, 0);
      chk("R5 sck pulses", sckr_c, DW + 1);
      chk("R5 sck high phases off", badhalf_c, 0);
      chk("R6 captured word", int'(vdata), int'(w));
      chk("R6 held word", int'(data_o), int'(w));
      chk("R7 valid pulses", vcnt_c, 1);
      chk("R7 cnv high at valid", int'(vcnv), 1);
      chk("R7 release after valid", vbad_c, 0);
      chk("R8 no timeout", tcnt_c, 0);
    end else begin
      chk("R8 timeout pulses", tcnt_c, 1);
      chk("R8 cnv low at timeout", tbad_c, 0);
      chk("R8 cnv high time", cnvhi_c, SDIHI + CMAX + MARGIN);
      chk("R8 no sck", sckr_c, 0);
      chk("R8 no valid", vcnt_c, 0);
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R4 watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    mon_clear(); hirun = 0; p_cnv = 0; p_sck = 0; p_valid = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset cnv", int'(cnv_o), 0);
    chk("R10 reset sdi", int'(sdi_o), 0);
    chk("R10 reset sck", int'(sck_o), 0);
    chk("R10 reset strobes", int'(valid_o | timeout_o), 0);
    chk("R10 reset ready", int'(ready_o), 1);
    chk("R10 reset data", int'(data_o), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R10 after release ready", int'(ready_o), 1);
    chk("R10 after release cnv", int'(cnv_o), 0);

    for (int v = 0; v < NVEC; v++) run_conv(VEC[v][15:0], VEC[v][16], 1'b0);

    // R1: request during the wait for end of conversion is dropped
    run_conv(16'h5A5A, 1'b1, 1'b1);

    // R1: request during acquisition is dropped, none started afterwards
    m_word = 16'h0F0F; m_respond = 1'b1;
    @(posedge clk); #1 mon_clear();
    pulse_start();
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1;
      if (fell_seen) break;
    end
    chk("R9 ready low after release", int'(ready_o), 0);
    start_i = 1'b1; @(posedge clk); #1 start_i = 1'b0;
    wait_done();
    repeat (30) @(posedge clk);
    #1;
    chk("R1 start during acquisition", rises_c, 1);
    chk("R1 idle after ignored start", int'(ready_o), 1);
    chk("R6 word after acquisition test", int'(data_o), 16'h0F0F);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule